// File: doc/BRIEF.md
# Sector Test Pattern Generator and Checker

This block produces and checks the test data used when a run of storage sectors is written and then read back. A command gives a starting sector address, a sector count, a direction (write or read-back) and a fill pattern. In write mode the block sends every beat of every sector on a valid/ready output stream. In read-back mode it accepts the returned stream, rebuilds each expected beat and compares the two.

Each sector opens with a header beat that carries the sector's own address, so a sector returned from the wrong place fails the compare even when its fill is correct. The remaining beats hold either a 32-bit counting fill or a 32-bit shift-register fill. Both fills restart from the sector address. A mismatch sets a sticky fail flag and is counted, and the address of the first failing sector is kept. The operation still runs to the last requested beat unless an abort input ends it early.

Top module: `sector_pattern_engine`

## Requirements
- R1: Beat 0 of each sector is a header equal to {16'h0000, 48-bit sector address}. The first sector's address is `cmd_lba`, and each following sector adds one.
- R2: A sector is 64 beats of 64 bits: the header, then 63 fill beats. Each fill beat holds two 32-bit words. The earlier word is in bits 31:0 and the later word is in bits 63:32.
- R3: With `cmd_pat`=0 (counting fill), word n of a sector (n counted from 0, after the header) equals the low 32 bits of the sector address plus n, modulo 2^32.
- R4: With `cmd_pat`=1 (shift-register fill), word 0 is the low 32 bits of the sector address, with zero replaced by 32'h00000001. Each later word is {prev[30:0], prev[31]^prev[21]^prev[1]^prev[0]}.
- R5: On either stream, a cycle without a handshake stalls the sequence. While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_data` holds its value. No word is skipped or repeated.
- R6: In read-back (`cmd_op`=1), any beat accepted with `rd_data` different from the expected beat sets `verify_fail`. The flag stays set until the next accepted command.
- R7: After a mismatch the read-back continues until every requested beat has been accepted. `fail_beats` counts the mismatched beats and saturates at its maximum. `first_fail_lba` holds the sector address of the first mismatch. Both are cleared by the next accepted command.
- R8: `cancel` high while busy ends the operation: in the next cycle `busy` is 0 and `done` is 1, and no further beats are taken.
- R9: A `cmd_start` pulse is accepted only while `busy` is 0. On acceptance `done` clears and `busy` rises in the next cycle. The cycle after the last beat's handshake, `busy` is 0 and `done` is 1. A `cmd_start` that arrives while busy has no effect.
- R10: A command with `cmd_count`=0 moves no beats. In the next cycle `busy` is 0 and `done` is 1.
- R11: `wr_valid` is high only during a busy write, and `rd_ready` is high only during a busy read-back. `verify_fail` only rises after an accepted read beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Command pulse |
| cmd_op | input | 1 | 0 = write, 1 = read-back |
| cmd_pat | input | 1 | 0 = counting fill, 1 = shift-register fill |
| cmd_lba | input | 48 | First sector address |
| cmd_count | input | 16 | Number of sectors |
| cancel | input | 1 | Abort the running operation |
| wr_valid | output | 1 | Write stream beat valid |
| wr_ready | input | 1 | Write stream sink ready |
| wr_data | output | 64 | Write stream beat |
| rd_valid | input | 1 | Read-back stream beat valid |
| rd_ready | output | 1 | Read-back stream accept |
| rd_data | input | 64 | Read-back stream beat |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation finished, held until the next command |
| verify_fail | output | 1 | Sticky compare failure |
| fail_beats | output | 16 | Count of mismatched beats |
| first_fail_lba | output | 48 | Sector address of the first mismatch |

## Verification
Some properties are checked on every cycle: a write beat holding steady under backpressure, the fail flag staying set between commands, `done` never overlapping `busy`, and both streams staying quiet when idle. The values of the data need the bench's scenarios. These include header addresses crossing the 32-bit boundary, the counting fill wrapping, the zero-seed substitution in the shift-register fill, and mismatches injected into chosen sectors and beats. The bench confirms that a run continues after a mismatch, that an abort stops it, and that a command arriving mid-run is ignored.

// File: rtl/spe_pkg.sv
package spe_pkg;
   typedef enum logic { OP_WRITE = 1'b0, OP_READ = 1'b1 } spe_op_e;
   typedef enum logic { FILL_COUNT = 1'b0, FILL_SHIFT = 1'b1 } spe_fill_e;
endpackage

// File: rtl/spe_fill_gen.sv
module spe_fill_gen
   import spe_pkg::*;
#(
   parameter int          ADDR_W       = 48,
   parameter int          DATA_W       = 64,
   parameter int          WORD_W       = 32,
   parameter int          SECTOR_BEATS = 64,
   parameter logic [31:0] LFSR_TAPS    = 32'h8020_0003,
   parameter logic [31:0] ZERO_SEED    = 32'h0000_0001,
   localparam int         WPB          = DATA_W / WORD_W,
   localparam int         BEAT_W       = $clog2(SECTOR_BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic [ADDR_W-1:0] init_addr,
   input  spe_fill_e         fill,
   input  logic              adv,
   output logic [DATA_W-1:0] beat_data,
   output logic              last_beat,
   output logic [ADDR_W-1:0] sec_addr
);
   logic [BEAT_W-1:0] beat_idx;
   logic [WORD_W-1:0] st;
   logic [WORD_W-1:0] seed;
   logic [WORD_W-1:0] st_next;
   logic [DATA_W-1:0] fill_beat;
   logic              is_shift;

   function automatic logic [WORD_W-1:0] shift_step(input logic [WORD_W-1:0] s);
      return {s[WORD_W-2:0], ^(s & LFSR_TAPS[WORD_W-1:0])};
   endfunction

   assign is_shift  = (fill == FILL_SHIFT);
   assign last_beat = (beat_idx == BEAT_W'(SECTOR_BEATS - 1));

   always_comb begin
      seed = sec_addr[WORD_W-1:0];
      if (is_shift && seed == '0) seed = ZERO_SEED[WORD_W-1:0];
   end

   for (genvar i = 0; i < WPB; i++) begin : g_chain
      logic [WORD_W-1:0] w_in;
      logic [WORD_W-1:0] w_out;
      if (i == 0) begin : g_first
         assign w_in = st;
      end else begin : g_next
         assign w_in = g_chain[i-1].w_out;
      end
      assign w_out = is_shift ? shift_step(w_in) : w_in + 1'b1;
      assign fill_beat[i*WORD_W +: WORD_W] = w_in;
   end
   assign st_next = g_chain[WPB-1].w_out;

   assign beat_data = (beat_idx == '0) ? {{(DATA_W-ADDR_W){1'b0}}, sec_addr} : fill_beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_idx <= '0;
         st       <= '0;
         sec_addr <= '0;
      end else if (init) begin
         beat_idx <= '0;
         sec_addr <= init_addr;
      end else if (adv) begin
         if (beat_idx == '0) st <= seed;
         else                st <= st_next;
         if (last_beat) begin
            beat_idx <= '0;
            sec_addr <= sec_addr + 1'b1;
         end else begin
            beat_idx <= beat_idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spe_seq.sv
module spe_seq
   import spe_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  spe_op_e          cmd_op,
   input  spe_fill_e        cmd_pat,
   input  logic [CNT_W-1:0] cmd_count,
   input  logic             cancel,
   input  logic             fire,
   input  logic             last_beat,
   output logic             accept,
   output logic             busy,
   output logic             done,
   output spe_op_e          op_q,
   output spe_fill_e        pat_q
);
   logic [CNT_W-1:0] left;

   assign accept = cmd_start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         left  <= '0;
         op_q  <= OP_WRITE;
         pat_q <= FILL_COUNT;
      end else if (accept) begin
         op_q  <= cmd_op;
         pat_q <= cmd_pat;
         left  <= cmd_count;
         if (cmd_count == '0) begin
            done <= 1'b1;
         end else begin
            done <= 1'b0;
            busy <= 1'b1;
         end
      end else if (busy) begin
         if (cancel) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else if (fire && last_beat) begin
            if (left == CNT_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
            left <= left - 1'b1;
         end
      end
   end
endmodule

// File: rtl/spe_cmp.sv
module spe_cmp #(
   parameter int ADDR_W = 48,
   parameter int DATA_W = 64,
   parameter int FAIL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              chk,
   input  logic [DATA_W-1:0] rcv,
   input  logic [DATA_W-1:0] expv,
   input  logic [ADDR_W-1:0] sec_addr,
   output logic              verify_fail,
   output logic [FAIL_W-1:0] fail_beats,
   output logic [ADDR_W-1:0] first_fail_lba
);
   logic miss;
   assign miss = chk && (rcv != expv);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         verify_fail    <= 1'b0;
         fail_beats     <= '0;
         first_fail_lba <= '0;
      end else if (clear) begin
         verify_fail    <= 1'b0;
         fail_beats     <= '0;
         first_fail_lba <= '0;
      end else if (miss) begin
         verify_fail <= 1'b1;
         if (!verify_fail) first_fail_lba <= sec_addr;
         if (fail_beats != '1) fail_beats <= fail_beats + 1'b1;
      end
   end
endmodule

// File: rtl/sector_pattern_engine.sv
module sector_pattern_engine
   import spe_pkg::*;
#(
   parameter int          ADDR_W       = 48,
   parameter int          CNT_W        = 16,
   parameter int          FAIL_W       = 16,
   parameter int          DATA_W       = 64,
   parameter int          WORD_W       = 32,
   parameter int          SECTOR_BEATS = 64,
   parameter logic [31:0] LFSR_TAPS    = 32'h8020_0003,
   parameter logic [31:0] ZERO_SEED    = 32'h0000_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_op,
   input  logic              cmd_pat,
   input  logic [ADDR_W-1:0] cmd_lba,
   input  logic [CNT_W-1:0]  cmd_count,
   input  logic              cancel,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              verify_fail,
   output logic [FAIL_W-1:0] fail_beats,
   output logic [ADDR_W-1:0] first_fail_lba
);
   if (ADDR_W >= DATA_W) begin : g_bad_addr
      $error("ADDR_W must be narrower than DATA_W");
   end
   if (WORD_W > 32 || DATA_W % WORD_W != 0 || DATA_W / WORD_W < 1) begin : g_bad_word
      $error("WORD_W must divide DATA_W and be at most 32");
   end
   if (SECTOR_BEATS < 2) begin : g_bad_beats
      $error("SECTOR_BEATS must be at least 2");
   end

   logic              accept;
   logic              fire;
   logic              last_beat;
   logic [DATA_W-1:0] exp_beat;
   logic [ADDR_W-1:0] sec_addr;
   spe_op_e           op_q;
   spe_fill_e         pat_q;

   spe_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_start (cmd_start),
      .cmd_op    (spe_op_e'(cmd_op)),
      .cmd_pat   (spe_fill_e'(cmd_pat)),
      .cmd_count (cmd_count),
      .cancel    (cancel),
      .fire      (fire),
      .last_beat (last_beat),
      .accept    (accept),
      .busy      (busy),
      .done      (done),
      .op_q      (op_q),
      .pat_q     (pat_q)
   );

   spe_fill_gen #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .WORD_W       (WORD_W),
      .SECTOR_BEATS (SECTOR_BEATS),
      .LFSR_TAPS    (LFSR_TAPS),
      .ZERO_SEED    (ZERO_SEED)
   ) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (accept),
      .init_addr (cmd_lba),
      .fill      (pat_q),
      .adv       (fire),
      .beat_data (exp_beat),
      .last_beat (last_beat),
      .sec_addr  (sec_addr)
   );

   assign wr_valid = busy && (op_q == OP_WRITE);
   assign rd_ready = busy && (op_q == OP_READ);
   assign wr_data  = exp_beat;
   assign fire     = (wr_valid && wr_ready) || (rd_valid && rd_ready);

   spe_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FAIL_W(FAIL_W)) u_cmp (
      .clk            (clk),
      .rst_n          (rst_n),
      .clear          (accept),
      .chk            (rd_valid && rd_ready),
      .rcv            (rd_data),
      .expv           (exp_beat),
      .sec_addr       (sec_addr),
      .verify_fail    (verify_fail),
      .fail_beats     (fail_beats),
      .first_fail_lba (first_fail_lba)
   );
endmodule

// File: rtl/spe_checks.sv
module spe_checks #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_start,
   input logic              cancel,
   input logic              busy,
   input logic              done,
   input logic              verify_fail,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_valid,
   input logic              rd_ready
);
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready && !cancel |=> wr_valid && $stable(wr_data)); // R5
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      verify_fail && !(cmd_start && !busy) |=> verify_fail); // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wr_valid && !rd_ready); // R11
   AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && rd_ready)); // R11
   AST_FAIL_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(verify_fail) |-> $past(rd_valid && rd_ready)); // R11
   AST_CANCEL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cancel |=> !busy && done); // R8
endmodule

bind sector_pattern_engine spe_checks #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_start   (cmd_start),
   .cancel      (cancel),
   .busy        (busy),
   .done        (done),
   .verify_fail (verify_fail),
   .wr_valid    (wr_valid),
   .wr_ready    (wr_ready),
   .wr_data     (wr_data),
   .rd_valid    (rd_valid),
   .rd_ready    (rd_ready)
);

// File: tb/sim_sector_pattern_engine.sv
`timescale 1ns/1ps
module sim_sector_pattern_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic        cmd_op = 1'b0;
   logic        cmd_pat = 1'b0;
   logic [47:0] cmd_lba = '0;
   logic [15:0] cmd_count = '0;
   logic        cancel = 1'b0;
   logic        wr_valid;
   logic        wr_ready = 1'b0;
   logic [63:0] wr_data;
   logic        rd_valid = 1'b0;
   logic        rd_ready;
   logic [63:0] rd_data = '0;
   logic        busy;
   logic        done;
   logic        verify_fail;
   logic [15:0] fail_beats;
   logic [47:0] first_fail_lba;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   sector_pattern_engine u0 (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
      .cmd_pat(cmd_pat), .cmd_lba(cmd_lba), .cmd_count(cmd_count), .cancel(cancel),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .busy(busy), .done(done), .verify_fail(verify_fail),
      .fail_beats(fail_beats), .first_fail_lba(first_fail_lba)
   );

   function automatic logic [31:0] shift_next(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   function automatic logic [63:0] model_beat(input logic [47:0] a, input int beat, input bit pat);
      logic [31:0] s;
      int j;
      if (beat == 0) return {16'h0000, a};
      s = a[31:0];
      j = 2 * (beat - 1);
      if (!pat) return {s + 32'(j + 1), s + 32'(j)};
      if (s == 32'h0) s = 32'h0000_0001;
      for (int k = 0; k < j; k++) s = shift_next(s);
      return {shift_next(s), s};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic issue(input bit op, input bit pat, input logic [47:0] lba, input logic [15:0] cnt);
      cmd_op = op; cmd_pat = pat; cmd_lba = lba; cmd_count = cnt; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic stream_write(input logic [47:0] lba, input int cnt, input bit pat,
                               input int stall, input bit poke);
      int idx = 0;
      int guard = 0;
      while (idx < cnt * 64 && guard < 40000) begin
         wr_ready = ($urandom % 100) >= stall;
         if (poke && idx == 10) begin
            cmd_start = 1'b1; cmd_lba = 48'hABCD; cmd_pat = ~pat;
         end
         #1;
         if (wr_valid && wr_ready) begin
            check(wr_data == model_beat(lba + 48'(idx / 64), idx % 64, pat),
                  (idx % 64 == 0) ? "R1 header" : (pat ? "R4 shift fill" : "R3 count fill"),
                  wr_data, model_beat(lba + 48'(idx / 64), idx % 64, pat));
            idx++;
         end else if (!wr_valid) begin
            check(1'b0, "R9 write stream dropped early", 64'(idx), 64'(cnt * 64));
            guard = 40000;
         end
         @(negedge clk);
         cmd_start = 1'b0;
         guard++;
      end
      wr_ready = 1'b0;
      check(!busy && done, "R9 done after last beat", {busy, done}, 2'b01);
   endtask

   task automatic stream_read(input logic [47:0] lba, input int cnt, input bit pat, input int stall,
                              input int err_a, input int err_b, input int stop_at, output int taken);
      int idx = 0;
      int guard = 0;
      while (idx < cnt * 64 && guard < 40000) begin
         rd_valid = ($urandom % 100) >= stall;
         rd_data = model_beat(lba + 48'(idx / 64), idx % 64, pat);
         if (idx == err_a || idx == err_b) rd_data = rd_data ^ 64'h0000_0100_0000_0000;
         if (idx == stop_at) cancel = 1'b1;
         #1;
         if (rd_valid && rd_ready) idx++;
         @(negedge clk);
         guard++;
         if (cancel) begin
            cancel = 1'b0;
            break;
         end
      end
      rd_valid = 1'b0;
      taken = idx;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int taken;
      logic [63:0] held;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !verify_fail && !wr_valid && !rd_ready, "R11 reset state",
            {busy, done, verify_fail, wr_valid, rd_ready}, 0);

      // R1 R2 R3: counting fill, no stalls
      issue(1'b0, 1'b0, 48'h10, 16'd2);
      check(busy && !done, "R9 busy after start", {busy, done}, 2'b10);
      stream_write(48'h10, 2, 1'b0, 0, 1'b0);

      // R4: zero address uses the substitute seed
      issue(1'b0, 1'b1, 48'h0, 16'd1);
      stream_write(48'h0, 1, 1'b1, 30, 1'b0);

      // R3 wrap, R1 header past 32 bits, R9 start ignored mid-run
      issue(1'b0, 1'b0, 48'h0000_FFFF_FFFF, 16'd2);
      stream_write(48'h0000_FFFF_FFFF, 2, 1'b0, 50, 1'b1);

      // R5 directed hold under backpressure
      issue(1'b0, 1'b1, 48'h7, 16'd1);
      wr_ready = 1'b1; #1;
      held = wr_data;
      @(negedge clk);
      wr_ready = 1'b0;
      held = wr_data;
      repeat (4) @(negedge clk);
      check(wr_valid && wr_data == held && held == model_beat(48'h7, 1, 1'b1), "R5 hold while stalled",
            wr_data, model_beat(48'h7, 1, 1'b1));
      wr_ready = 1'b1; #1;
      check(wr_data == model_beat(48'h7, 1, 1'b1), "R5 no skip after stall", wr_data, model_beat(48'h7, 1, 1'b1));
      @(negedge clk);
      #1;
      check(wr_data == model_beat(48'h7, 2, 1'b1), "R5 next beat after stall", wr_data, model_beat(48'h7, 2, 1'b1));
      while (busy) @(negedge clk);
      wr_ready = 1'b0;
      check(done, "R9 done after stalled run", 64'(done), 1);

      // R6: clean read-back
      issue(1'b1, 1'b1, 48'h1234, 16'd2);
      stream_read(48'h1234, 2, 1'b1, 40, -1, -1, -1, taken);
      check(!verify_fail && fail_beats == 0 && done && !busy, "R6 clean read no fail",
            {verify_fail, fail_beats}, 0);

      // R7: two errors, run continues to the end
      issue(1'b1, 1'b0, 48'h500, 16'd3);
      stream_read(48'h500, 3, 1'b0, 20, 69, 128, -1, taken);
      check(taken == 192 && done && !busy, "R7 run continues after mismatch", 64'(taken), 192);
      check(verify_fail, "R6 fail flag set", 64'(verify_fail), 1);
      check(fail_beats == 16'd2, "R7 mismatch count", 64'(fail_beats), 2);
      check(first_fail_lba == 48'h501, "R7 first failing sector", 64'(first_fail_lba), 64'h501);
      repeat (5) @(negedge clk);
      check(verify_fail, "R6 flag sticky while idle", 64'(verify_fail), 1);

      // R10: zero count, also clears fail state
      issue(1'b0, 1'b0, 48'h99, 16'd0);
      check(!busy && done && !wr_valid, "R10 zero count finishes", {busy, done, wr_valid}, 3'b010);
      check(!verify_fail && fail_beats == 0, "R6 cleared by next command", {verify_fail, fail_beats}, 0);

      // R8: mismatch then abort
      issue(1'b1, 1'b1, 48'h2_0000_0040, 16'd4);
      stream_read(48'h2_0000_0040, 4, 1'b1, 0, 3, -1, 20, taken);
      check(!busy && done, "R8 abort ends run", {busy, done}, 2'b01);
      check(taken <= 21, "R8 beats stop at abort", 64'(taken), 21);
      check(verify_fail && fail_beats == 1 && first_fail_lba == 48'h2_0000_0040, "R8 fail state kept",
            {verify_fail, fail_beats}, {1'b1, 16'd1});
      @(negedge clk);
      check(!rd_ready, "R11 no accept after abort", 64'(rd_ready), 0);

      // random mix
      for (int t = 0; t < 8; t++) begin
         logic [47:0] a;
         int n;
         bit p;
         a = {16'($urandom), $urandom};
         n = 1 + ($urandom % 2);
         p = 1'($urandom);
         if ($urandom % 2) begin
            issue(1'b0, p, a, 16'(n));
            stream_write(a, n, p, $urandom % 60, 1'b0);
         end else begin
            issue(1'b1, p, a, 16'(n));
            stream_read(a, n, p, $urandom % 60, -1, -1, -1, taken);
            check(!verify_fail && taken == n * 64, "R6 random read clean", 64'(taken), 64'(n * 64));
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule